// File: doc/BRIEF.md
# Special-Function Register Bank

This block holds a small set of 16-bit control and status registers that a CPU reaches over its data bus. A single access port carries word, byte and single-bit reads and writes. The block decodes the access itself, either from a long 16-bit memory address plus the current data page number, or from a short 8-bit register number that lands in one of two 512-byte windows. The extended window is used while `ext_i` is high. A short register number `n` maps to byte address `base + 2*n`. The base is 0xFE00 for the standard window and 0xF000 for the extended window.

Each register has four compile-time properties: its address, its reset value, a mask of implemented bits and a mask of the bits software may write. Registers with an empty software mask, such as the program counter and the code segment register, change only through the hardware update port. Implemented bits that fall outside the software mask are hardware-owned status flags. Every register value is exported in parallel on `regs_o` so that surrounding logic can use it.

Top module: `sfr_bank`

Default map: 0xFF00 control (all bits software-writable), 0xFF02 status (low byte implemented, bits 7:4 software, bits 3:0 hardware-only), 0xFF04 program counter (protected), 0xFF06 segment (low byte, protected), 0xF000 extended A (reset 0x1234), 0xF0FE extended B (bits 11:8 and 3:0, reset 0x0A05).

## Requirements
- R1: A word write (op_i=0) to a claimed register loads its software-writable bits from wdata_i on the next rising edge and leaves every other register unchanged.
- R2: A byte write (op_i=1) loads wdata_i[7:0] into the selected lane and clears the writable bits of the other lane. The lane is addr_i[0] for long accesses and hi_byte_i for short ones, with 1 selecting bits 15:8.
- R3: A byte read returns the selected lane in rdata_o[7:0] with rdata_o[15:8]=0, and no read changes any register.
- R4: Bits outside a register's implemented mask ignore every write and always read 0.
- R5: A claimed address that holds no register reads 0xFFFF on a word access and 0x00FF on a byte access, and writes to it have no effect.
- R6: A protected register (software mask zero) ignores all bus writes and changes only when its hw_we_i bit is set.
- R7: A software write that lands on a register in the same cycle as a hardware update wins, and the hardware value is dropped. A software write lands when it has at least one writable target bit.
- R8: A short access (long_i=0) targets 0xFE00+2*addr_i[7:0] when ext_i=0 and 0xF000+2*addr_i[7:0] when ext_i=1, and is always claimed.
- R9: A long access (long_i=1) targets {2'b11, addr_i[13:0]} and is claimed only when page_i equals 3 and the address lies in 0xF000-0xF1FF or 0xFE00-0xFFFF. An unclaimed or idle access gives hit_o=0 and rdata_o=0 and writes nothing.
- R10: A bit write (op_i=2) sets or clears bit bit_idx_i to wdata_i[0] when that bit is software-writable, and leaves every other bit unchanged. When the bit is not writable the write is ignored.
- R11: Hardware-only status bits keep their value through word and byte writes to their register.
- R12: While rst_ni is low, every register holds its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| long_i | input | 1 | 1 = long address with page, 0 = short register number |
| ext_i | input | 1 | Short accesses use the extended window |
| op_i | input | 2 | 0 word, 1 byte, 2 bit |
| hi_byte_i | input | 1 | Byte lane for short byte accesses |
| bit_idx_i | input | 4 | Bit number for bit writes |
| page_i | input | PAGE_W | Data page number for long accesses |
| addr_i | input | OFF_W | Long: page offset; short: register number in bits 7:0 |
| wdata_i | input | 16 | Write data |
| hw_we_i | input | NUM_REGS | Hardware update strobe, one per register |
| hw_wdata_i | input | 16*NUM_REGS | Hardware update values, register k in bits 16k+15:16k |
| rdata_o | output | 16 | Read data |
| hit_o | output | 1 | Access claimed by this block |
| regs_o | output | 16*NUM_REGS | Current register values |

## Verification
The bench goes after the collision cycle, where a software write and a hardware update hit one register together. A reversed priority would leave the hardware value in the register. Byte writes are checked on both lanes: an implementation that merged instead of clearing would keep stale data in the other lane. It also covers short accesses under both values of `ext_i`, along with long accesses on page 2 and on page 3 outside the windows. A decoder that skipped the page or window test would claim these accesses and corrupt registers. Protected and hardware-only bits are hammered with all-ones writes. Any leak in a mask shows up at once on `regs_o`, because the reference model compares every register on every clock.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int unsigned DW          = 16;
  localparam int unsigned NUM_DEF     = 6;
  localparam logic [15:0] STD_BASE    = 16'hFE00;
  localparam logic [15:0] EXT_BASE    = 16'hF000;

  typedef enum logic [1:0] {
    OP_WORD = 2'd0,
    OP_BYTE = 2'd1,
    OP_BIT  = 2'd2
  } sfr_op_e;

  function automatic logic [15:0] cfg_addr(int unsigned i);
    case (i)
      0: return 16'hFF00;
      1: return 16'hFF02;
      2: return 16'hFF04;
      3: return 16'hFF06;
      4: return 16'hF000;
      5: return 16'hF0FE;
      default: return 16'h0000;  // never inside a window
    endcase
  endfunction

  function automatic logic [15:0] cfg_rst(int unsigned i);
    case (i)
      4: return 16'h1234;
      5: return 16'h0A05;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] cfg_impl(int unsigned i);
    case (i)
      1, 3: return 16'h00FF;
      5: return 16'h0F0F;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [15:0] cfg_swm(int unsigned i);
    case (i)
      1: return 16'h00F0;
      2, 3: return 16'h0000;
      5: return 16'h0F0F;
      default: return 16'hFFFF;
    endcase
  endfunction
endpackage

// File: rtl/sfr_decode.sv
module sfr_decode #(
  parameter int unsigned NUM_REGS = sfr_pkg::NUM_DEF,
  parameter int unsigned PAGE_W   = 10,
  parameter int unsigned OFF_W    = 14
) (
  input  logic                req_i,
  input  logic                long_i,
  input  logic                ext_i,
  input  logic                hi_byte_i,
  input  logic [PAGE_W-1:0]   page_i,
  input  logic [OFF_W-1:0]    addr_i,
  output logic                claim_o,
  output logic                hi_lane_o,
  output logic [NUM_REGS-1:0] sel_o
);
  import sfr_pkg::*;

  logic [15:0] phys;
  logic        in_win;

  always_comb begin
    if (long_i) phys = {2'b11, addr_i[13:0]};
    else        phys = (ext_i ? EXT_BASE : STD_BASE) + {7'd0, addr_i[7:0], 1'b0};
  end

  assign in_win    = (phys[15:9] == 7'b1111111) || (phys[15:9] == 7'b1111000);
  assign claim_o   = req_i && (!long_i || (page_i == PAGE_W'(3) && in_win));
  assign hi_lane_o = long_i ? phys[0] : hi_byte_i;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_match
    localparam logic [15:0] A = cfg_addr(i);
    assign sel_o[i] = claim_o && (phys[15:1] == A[15:1]);
  end
endmodule

// File: rtl/sfr_cell.sv
module sfr_cell #(
  parameter logic [15:0] RST  = 16'h0000,
  parameter logic [15:0] IMPL = 16'hFFFF,
  parameter logic [15:0] SWM  = 16'hFFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sw_sel_i,
  input  logic [1:0]  op_i,
  input  logic        hi_lane_i,
  input  logic [3:0]  bit_idx_i,
  input  logic [15:0] wdata_i,
  input  logic        hw_we_i,
  input  logic [15:0] hw_wdata_i,
  output logic [15:0] q_o
);
  import sfr_pkg::*;

  localparam logic [15:0] WM = SWM & IMPL;

  logic [15:0] q, sw_val, eff, nxt;
  logic        sw_take;

  always_comb begin
    case (op_i)
      OP_BYTE: begin
        sw_val = hi_lane_i ? {wdata_i[7:0], 8'h00} : {8'h00, wdata_i[7:0]};
        eff    = WM;
      end
      OP_BIT: begin
        sw_val = {16{wdata_i[0]}};
        eff    = WM & (16'h0001 << bit_idx_i);
      end
      default: begin
        sw_val = wdata_i;
        eff    = WM;
      end
    endcase
    sw_take = sw_sel_i && (eff != '0);
    // software wins over a concurrent hardware update
    if (sw_take)      nxt = (q & ~eff) | (sw_val & eff);
    else if (hw_we_i) nxt = hw_wdata_i & IMPL;
    else              nxt = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST & IMPL;
    else         q <= nxt;
  end

  assign q_o = q;
endmodule

// File: rtl/sfr_rdmux.sv
module sfr_rdmux #(
  parameter int unsigned NUM_REGS = sfr_pkg::NUM_DEF
) (
  input  logic                   claim_i,
  input  logic [NUM_REGS-1:0]    sel_i,
  input  logic [1:0]             op_i,
  input  logic                   hi_lane_i,
  input  logic [NUM_REGS*16-1:0] regs_i,
  output logic [15:0]            rdata_o
);
  import sfr_pkg::*;

  logic [15:0] word;

  always_comb begin
    word = (sel_i == '0) ? 16'hFFFF : 16'h0000;
    for (int i = 0; i < NUM_REGS; i++)
      if (sel_i[i]) word = word | regs_i[i*16 +: 16];
    if (!claim_i)                       rdata_o = 16'h0000;
    else if (op_i == OP_BYTE)           rdata_o = {8'h00, hi_lane_i ? word[15:8] : word[7:0]};
    else                                rdata_o = word;
  end
endmodule

// File: rtl/sfr_bank.sv
module sfr_bank #(
  parameter int unsigned NUM_REGS = sfr_pkg::NUM_DEF,
  parameter int unsigned PAGE_W   = 10,
  parameter int unsigned OFF_W    = 14
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic                   long_i,
  input  logic                   ext_i,
  input  logic [1:0]             op_i,
  input  logic                   hi_byte_i,
  input  logic [3:0]             bit_idx_i,
  input  logic [PAGE_W-1:0]      page_i,
  input  logic [OFF_W-1:0]       addr_i,
  input  logic [15:0]            wdata_i,
  input  logic [NUM_REGS-1:0]    hw_we_i,
  input  logic [NUM_REGS*16-1:0] hw_wdata_i,
  output logic [15:0]            rdata_o,
  output logic                   hit_o,
  output logic [NUM_REGS*16-1:0] regs_o
);
  import sfr_pkg::*;

  logic                claim, hi_lane;
  logic [NUM_REGS-1:0] sel;

  sfr_decode #(.NUM_REGS(NUM_REGS), .PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_dec (
    .req_i(req_i), .long_i(long_i), .ext_i(ext_i), .hi_byte_i(hi_byte_i),
    .page_i(page_i), .addr_i(addr_i),
    .claim_o(claim), .hi_lane_o(hi_lane), .sel_o(sel)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    sfr_cell #(.RST(cfg_rst(i)), .IMPL(cfg_impl(i)), .SWM(cfg_swm(i))) u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .sw_sel_i(we_i && sel[i]), .op_i(op_i), .hi_lane_i(hi_lane),
      .bit_idx_i(bit_idx_i), .wdata_i(wdata_i),
      .hw_we_i(hw_we_i[i]), .hw_wdata_i(hw_wdata_i[i*16 +: 16]),
      .q_o(regs_o[i*16 +: 16])
    );
  end

  sfr_rdmux #(.NUM_REGS(NUM_REGS)) u_rd (
    .claim_i(claim), .sel_i(sel), .op_i(op_i), .hi_lane_i(hi_lane),
    .regs_i(regs_o), .rdata_o(rdata_o)
  );

  assign hit_o = claim;
endmodule

// File: rtl/sfr_bank_chk.sv
module sfr_bank_chk #(
  parameter int unsigned NUM_REGS = sfr_pkg::NUM_DEF
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_i,
  input logic                   we_i,
  input logic [1:0]             op_i,
  input logic                   hit_o,
  input logic [15:0]            rdata_o,
  input logic [NUM_REGS-1:0]    hw_we_i,
  input logic [NUM_REGS*16-1:0] regs_o
);
  import sfr_pkg::*;

  AST_NOHIT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> rdata_o == 16'h0000); // R9

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == OP_BYTE) |-> rdata_o[15:8] == 8'h00); // R3

  AST_READ_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(req_i && we_i) && hw_we_i == '0) |=> $stable(regs_o)); // R3

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    localparam logic [15:0] IMPL = cfg_impl(i);
    AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (regs_o[i*16 +: 16] & ~IMPL) == 16'h0000); // R4
    if (cfg_swm(i) == 16'h0000) begin : g_prot
      AST_PROT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hw_we_i[i] |=> $stable(regs_o[i*16 +: 16])); // R6
    end
  end
endmodule

bind sfr_bank sfr_bank_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .op_i(op_i),
  .hit_o(hit_o), .rdata_o(rdata_o), .hw_we_i(hw_we_i), .regs_o(regs_o)
);

// File: tb/sfr_bank_tb.sv
module sfr_bank_tb;
  localparam int N = 6;

  logic          clk_i = 0, rst_ni = 0;
  logic          req_i = 0, we_i = 0, long_i = 0, ext_i = 0, hi_byte_i = 0;
  logic [1:0]    op_i = 0;
  logic [3:0]    bit_idx_i = 0;
  logic [9:0]    page_i = 0;
  logic [13:0]   addr_i = 0;
  logic [15:0]   wdata_i = 0;
  logic [N-1:0]  hw_we_i = 0;
  logic [N*16-1:0] hw_wdata_i = 0;
  logic [15:0]   rdata_o;
  logic          hit_o;
  logic [N*16-1:0] regs_o;

  sfr_bank u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int unsigned t_addr[N] = '{16'hFF00, 16'hFF02, 16'hFF04, 16'hFF06, 16'hF000, 16'hF0FE};
  int unsigned t_rst [N] = '{0, 0, 0, 0, 16'h1234, 16'h0A05};
  int unsigned t_impl[N] = '{16'hFFFF, 16'h00FF, 16'hFFFF, 16'h00FF, 16'hFFFF, 16'h0F0F};
  int unsigned t_sw  [N] = '{16'hFFFF, 16'h00F0, 0, 0, 16'hFFFF, 16'h0F0F};
  int unsigned model[N];
  int compared = 0, mismatched = 0;
  bit done = 0;

  task automatic check(string tag, string what, int unsigned act, int unsigned exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_regs(string tag);
    for (int k = 0; k < N; k++) check(tag, $sformatf("reg%0d", k), regs_o[k*16 +: 16], model[k]);
  endtask

  // one bus cycle; starts and ends at a falling edge
  task automatic cyc(string tag, bit rq, bit w, bit lg, bit ex, int op, bit hb,
                     int bidx, int pg, int unsigned ad, int unsigned wd,
                     int hwmask, int unsigned hwv);
    int unsigned phys, exp_rd, word, eff, val;
    int k;
    bit claim;
    int unsigned nxt[N];
    req_i = rq; we_i = w; long_i = lg; ext_i = ex; op_i = 2'(op); hi_byte_i = hb;
    bit_idx_i = 4'(bidx); page_i = 10'(pg); addr_i = 14'(ad); wdata_i = 16'(wd);
    hw_we_i = N'(hwmask);
    for (int j = 0; j < N; j++) hw_wdata_i[j*16 +: 16] = 16'(hwv);
    if (lg) begin
      phys = 32'hC000 + (ad & 32'h3FFF);
      claim = rq && pg == 3 && ((phys >= 32'hF000 && phys < 32'hF200) || phys >= 32'hFE00);
      hb = phys[0];
    end else begin
      phys = (ex ? 32'hF000 : 32'hFE00) + 2 * (ad & 32'hFF);
      claim = rq;
    end
    k = -1;
    for (int j = 0; j < N; j++) if (claim && (t_addr[j] >> 1) == (phys >> 1)) k = j;
    word = !claim ? 0 : (k < 0 ? 32'hFFFF : model[k]);
    exp_rd = (claim && op == 1) ? (hb ? (word >> 8) : (word & 32'hFF)) : word;
    #1;
    check(tag, "hit", hit_o, claim);
    if (!w) check(tag, "rdata", rdata_o, exp_rd);
    for (int j = 0; j < N; j++) begin
      nxt[j] = model[j];
      if (hwmask[j]) nxt[j] = hwv & t_impl[j];
    end
    if (w && k >= 0) begin
      eff = t_sw[k] & t_impl[k];
      val = wd & 32'hFFFF;
      if (op == 1) val = hb ? ((wd & 32'hFF) << 8) : (wd & 32'hFF);
      if (op == 2) begin eff = eff & (1 << bidx); val = wd[0] ? 32'hFFFF : 0; end
      if (eff != 0) nxt[k] = (model[k] & ~eff) | (val & eff);
    end
    @(posedge clk_i);
    model = nxt;
    @(negedge clk_i);
    check_regs(tag);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < N; j++) model[j] = t_rst[j];
    repeat (3) @(negedge clk_i);
    check_regs("R12");
    rst_ni = 1;
    @(negedge clk_i);
    // R12 reset value visible through a short extended read
    cyc("R12", 1, 0, 0, 1, 0, 0, 0, 0, 8'h00, 0, 0, 0);
    // R1 word write, read back through long addressing
    cyc("R1", 1, 1, 0, 0, 0, 0, 0, 0, 8'h80, 16'hA5C3, 0, 0);
    cyc("R9", 1, 0, 1, 0, 0, 0, 0, 3, 14'h3F00, 0, 0, 0);
    // R2 byte writes on both lanes
    cyc("R2", 1, 1, 0, 0, 1, 1, 0, 0, 8'h80, 16'h0077, 0, 0);
    cyc("R2", 1, 1, 0, 0, 1, 0, 0, 0, 8'h80, 16'h0011, 0, 0);
    cyc("R2", 1, 1, 1, 0, 1, 0, 0, 3, 14'h3001, 16'h00C9, 0, 0);
    // R3 byte reads
    cyc("R3", 1, 0, 0, 1, 1, 1, 0, 0, 8'h00, 0, 0, 0);
    cyc("R3", 1, 0, 0, 1, 1, 0, 0, 0, 8'h00, 0, 0, 0);
    cyc("R3", 1, 0, 1, 0, 1, 0, 0, 3, 14'h3F01, 0, 0, 0);
    // R4 reserved bits, R11 hardware-only flags
    cyc("R4", 1, 1, 0, 1, 0, 0, 0, 0, 8'h7F, 16'hFFFF, 0, 0);
    cyc("R11", 1, 1, 0, 0, 0, 0, 0, 0, 8'h81, 16'hFFFF, 0, 0);
    cyc("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 6'b000010, 16'h0F03);
    cyc("R11", 1, 1, 0, 0, 1, 0, 0, 0, 8'h81, 16'h005F, 0, 0);
    // R5 unimplemented location
    cyc("R5", 1, 0, 0, 0, 0, 0, 0, 0, 8'h90, 0, 0, 0);
    cyc("R5", 1, 0, 0, 0, 1, 1, 0, 0, 8'h90, 0, 0, 0);
    cyc("R5", 1, 1, 0, 0, 0, 0, 0, 0, 8'h90, 16'h1111, 0, 0);
    // R6 protected registers
    cyc("R6", 1, 1, 0, 0, 0, 0, 0, 0, 8'h82, 16'hBEEF, 0, 0);
    cyc("R6", 1, 1, 0, 0, 2, 0, 3, 0, 8'h83, 16'h0001, 0, 0);
    cyc("R6", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 6'b000100, 16'h1000);
    cyc("R6", 1, 1, 0, 0, 0, 0, 0, 0, 8'h82, 16'hFFFF, 6'b000100, 16'h2468);
    // R7 collisions
    cyc("R7", 1, 1, 0, 0, 0, 0, 0, 0, 8'h80, 16'h5555, 6'b000001, 16'hAAAA);
    cyc("R7", 1, 1, 0, 0, 0, 0, 0, 0, 8'h81, 16'h00A0, 6'b000010, 16'h000C);
    cyc("R7", 1, 1, 0, 1, 1, 1, 0, 0, 8'h00, 16'h00EE, 6'b010001, 16'h0F0F);
    // R8 window selection by ext_i
    cyc("R8", 1, 0, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0);
    cyc("R8", 1, 0, 0, 1, 0, 0, 0, 0, 8'h00, 0, 0, 0);
    cyc("R8", 1, 1, 0, 0, 0, 0, 0, 0, 8'h7F, 16'h0303, 0, 0);
    cyc("R8", 1, 0, 0, 1, 0, 0, 0, 0, 8'h7F, 0, 0, 0);
    // R9 long access claim rules
    cyc("R9", 1, 0, 1, 0, 0, 0, 0, 2, 14'h3F00, 0, 0, 0);
    cyc("R9", 1, 1, 1, 0, 0, 0, 0, 2, 14'h3F00, 16'hDEAD, 0, 0);
    cyc("R9", 1, 1, 1, 0, 0, 0, 0, 3, 14'h0000, 16'hDEAD, 0, 0);
    cyc("R9", 1, 0, 1, 0, 0, 0, 0, 3, 14'h3000, 0, 0, 0);
    cyc("R9", 1, 1, 1, 0, 0, 0, 0, 3, 14'h30FE, 16'hFFFF, 0, 0);
    // R10 bit writes
    cyc("R10", 1, 1, 0, 0, 2, 0, 15, 0, 8'h80, 16'h0001, 0, 0);
    cyc("R10", 1, 1, 0, 0, 2, 0, 0, 0, 8'h80, 16'h0000, 0, 0);
    cyc("R10", 1, 1, 0, 0, 2, 0, 1, 0, 8'h81, 16'h0001, 6'b000010, 16'h0009);
    cyc("R10", 1, 1, 0, 0, 2, 0, 6, 0, 8'h81, 16'h0001, 6'b000010, 16'h0000);
    cyc("R10", 1, 1, 0, 1, 2, 0, 12, 0, 8'h7F, 16'h0001, 0, 0);
    // R3 reads leave state alone across idle cycles
    cyc("R3", 1, 0, 0, 0, 0, 0, 0, 0, 8'h81, 0, 0, 0);
    idle("R9");
    // R12 reset restores defaults
    rst_ni = 0;
    for (int j = 0; j < N; j++) model[j] = t_rst[j];
    @(negedge clk_i);
    check_regs("R12");
    rst_ni = 1;
    idle("R12");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule